// File: doc/BRIEF.md
# Comparator Event Timer

This block is a memory-mapped event timer. A free-running 64-bit up-counter advances once per clock while a global run bit is set. Several comparator channels watch it, and each channel raises a level interrupt when the counter equals its comparator. A channel fires once per comparator value in one-shot mode. In periodic mode the channel adds a programmed period to its own comparator after every match, so software can see each tick by watching the comparator change, and the counter is never cleared.

Software reaches the block through a simple word-addressed register bus. A write strobe carries an address and a 32-bit data word. The read data is a combinational function of the address. The registers are a read-only identity word, a read-only tick-period word in femtoseconds, a general control word, a pending-status word, the two counter halves and, for each channel, a control word and the two comparator halves. A compatibility mode in the general control word sends channel 0 to a dedicated system-tick interrupt pin and channel 1 to a dedicated clock-alarm pin. All other routing uses a per-channel line-select field.

Top module: `event_timer`

## Requirements
- R1: After reset the counter, general control, pending status and every channel control word read 0, every comparator half reads 0xFFFFFFFF, and all interrupt outputs are low.
- R2: Word 0 is read-only and reads the channel count minus one in bits [4:0] and the compatibility-mode capability in bit 7. Word 1 reads the tick period TICK_FS, which lies between 100,000 and 100,000,000.
- R3: While bit 0 of the general control word (word 2) is set, the counter advances by one every clock. While it is clear, the counter holds its value.
- R4: Words 4 and 5 write the low and high counter halves only while the counter is stopped. Writes made while it runs are ignored.
- R5: Unimplemented word offsets read as 0, and writes to them change nothing.
- R6: A channel whose interrupt-enable bit (control bit 0) is set sets its pending bit when the counter equals its comparator. The pending bit, seen at status word 3 bit n and on the routed interrupt output, stays high until software writes 1 to that status bit. In one-shot mode the comparator is left unchanged.
- R7: In periodic mode (control bit 1), each match adds the period to the comparator, and the counter keeps counting.
- R8: Writing control bit 2 (set-value) arms a two-step load. The next comparator write loads the comparator, and the one after it loads the period. Bit 2 always reads back as 0.
- R9: With control bit 3 set, only the low 32 bits are compared. A one-shot comparator that is already behind the counter fires only after the low half wraps around.
- R10: With bit 1 of word 2 set, channel 0 drives only irq_tick and channel 1 drives only irq_rtc. With bit 1 clear, both of those pins stay low.
- R11: A channel not taken by the compatibility mode drives irq_line[route], where route is control bits [5:4].
- R12: With interrupt-enable clear, a match sets no pending bit and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_tick | output | 1 | Compatibility system-tick interrupt |
| irq_rtc | output | 1 | Compatibility clock-alarm interrupt |
| irq_line | output | NLINE | Routed interrupt lines |

## Verification
The bench first checks the exact counter value at which each interrupt first becomes visible. This exposes any off-by-one between the counter register and the match, or a match taken against the next counter value. It then runs a periodic channel through two matches and checks both the advanced comparator and a counter that kept counting. A design that cleared the counter or added the period twice would read different values there. The set-value sequence is checked by reading the comparator after the two loads: a design that swapped the two targets would show the period in the comparator. A 32-bit channel is set behind a counter near the top of its low half, and the bench confirms that it stays silent until the wrap and then fires with a carry in the high half. A design that compared all 64 bits would never fire, and one using a magnitude test would fire at once.

// File: rtl/et_pkg.sv
package et_pkg;
    localparam int DW = 32;
    localparam int CW = 2 * DW;

    localparam logic [31:0] FS_MIN = 32'd100000;
    localparam logic [31:0] FS_MAX = 32'd100000000;

    // word offsets of the global registers
    localparam int A_ID     = 0;
    localparam int A_PERIOD = 1;
    localparam int A_GCFG   = 2;
    localparam int A_STAT   = 3;
    localparam int A_CNT_LO = 4;
    localparam int A_CNT_HI = 5;

    // channel window: base + stride * channel + slot
    localparam int A_CH_BASE   = 8;
    localparam int A_CH_STRIDE = 4;
    localparam int S_CFG    = 0;
    localparam int S_CMP_LO = 1;
    localparam int S_CMP_HI = 2;

    // channel control bit positions
    localparam int B_IE    = 0;
    localparam int B_PER   = 1;
    localparam int B_SETV  = 2;
    localparam int B_M32   = 3;
    localparam int B_ROUTE = 4;

    // global control bit positions
    localparam int G_RUN = 0;
    localparam int G_LEG = 1;

    typedef enum logic [1:0] {
        LD_NORM = 2'd0,
        LD_CMP  = 2'd1,
        LD_PER  = 2'd2
    } ld_phase_e;
endpackage

// File: rtl/et_counter.sv
module et_counter
    import et_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [DW-1:0] wdata,
    output logic [CW-1:0] cnt
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_st_t;

    cnt_st_t s_d, s_q;

    // R3 advance while running; R4 half loads only while stopped
    always_comb begin
        s_d = s_q;
        if (run) begin
            s_d.cnt = s_q.cnt + CW'(1);
        end else begin
            if (wr_lo) s_d.cnt[DW-1:0]  = wdata;
            if (wr_hi) s_d.cnt[CW-1:DW] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt = s_q.cnt;
endmodule

// File: rtl/et_channel.sv
module et_channel
    import et_pkg::*;
#(
    parameter int ROUTE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [CW-1:0]      cnt,
    input  logic               wr_cfg,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [DW-1:0]      wdata,
    input  logic               clr,
    output logic [DW-1:0]      cfg_rd,
    output logic [CW-1:0]      cmp,
    output logic               pend,
    output logic               irq,
    output logic [ROUTE_W-1:0] route
);
    typedef struct packed {
        logic               ie;
        logic               per;
        logic               m32;
        logic [ROUTE_W-1:0] route;
        ld_phase_e          ph;
        logic [CW-1:0]      cmp;
        logic [CW-1:0]      prd;
        logic               pend;
    } ch_st_t;

    localparam ch_st_t CH_RST = '{
        ie: 1'b0, per: 1'b0, m32: 1'b0, route: '0, ph: LD_NORM,
        cmp: '1, prd: '0, pend: 1'b0
    };

    ch_st_t s_d, s_q;
    logic   hit;

    always_comb begin
        s_d = s_q;

        // R6 / R9 equality match, low half only in 32-bit mode
        if (s_q.m32) hit = run && (cnt[DW-1:0] == s_q.cmp[DW-1:0]);
        else         hit = run && (cnt == s_q.cmp);

        // clear first so that a match in the same cycle wins
        if (clr) s_d.pend = 1'b0;

        if (hit) begin
            if (s_q.ie) s_d.pend = 1'b1;                 // R12 gated by enable
            if (s_q.per) begin                           // R7 self-advance
                if (s_q.m32)
                    s_d.cmp[DW-1:0] = s_q.cmp[DW-1:0] + s_q.prd[DW-1:0];
                else
                    s_d.cmp = s_q.cmp + s_q.prd;
            end
        end

        if (wr_cfg) begin
            s_d.ie    = wdata[B_IE];
            s_d.per   = wdata[B_PER];
            s_d.m32   = wdata[B_M32];
            s_d.route = wdata[B_ROUTE +: ROUTE_W];
            if (wdata[B_SETV]) s_d.ph = LD_CMP;          // R8 arm the load
        end

        // bus writes take priority over the automatic advance
        if (wr_lo || wr_hi) begin
            case (s_q.ph)
                LD_PER: begin
                    if (wr_lo) s_d.prd[DW-1:0]  = wdata;
                    if (wr_hi) s_d.prd[CW-1:DW] = wdata;
                    s_d.ph = LD_NORM;
                end
                LD_CMP: begin
                    if (wr_lo) s_d.cmp[DW-1:0]  = wdata;
                    if (wr_hi) s_d.cmp[CW-1:DW] = wdata;
                    s_d.ph = LD_PER;
                end
                default: begin
                    if (wr_lo) s_d.cmp[DW-1:0]  = wdata;
                    if (wr_hi) s_d.cmp[CW-1:DW] = wdata;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= CH_RST;
        else        s_q <= s_d;
    end

    always_comb begin
        cfg_rd                       = '0;
        cfg_rd[B_IE]                 = s_q.ie;
        cfg_rd[B_PER]                = s_q.per;
        cfg_rd[B_M32]                = s_q.m32;
        cfg_rd[B_ROUTE +: ROUTE_W]   = s_q.route;
    end

    assign cmp   = s_q.cmp;
    assign pend  = s_q.pend;
    assign irq   = s_q.pend & s_q.ie;
    assign route = s_q.route;
endmodule

// File: rtl/et_irq_route.sv
module et_irq_route #(
    parameter int NCH     = 3,
    parameter int NLINE   = 4,
    parameter int ROUTE_W = 2
) (
    input  logic [NCH-1:0]         irq,
    input  logic [NCH*ROUTE_W-1:0] route_flat,
    input  logic                   legacy,
    output logic                   irq_tick,
    output logic                   irq_rtc,
    output logic [NLINE-1:0]       irq_line
);
    // R10 fixed pins in compatibility mode, R11 per-channel line select
    always_comb begin
        irq_tick = legacy & irq[0];
        irq_rtc  = legacy & irq[1];
        irq_line = '0;
        for (int c = 0; c < NCH; c++) begin
            if (!(legacy && (c < 2))) begin
                for (int l = 0; l < NLINE; l++) begin
                    if (irq[c] && (route_flat[c*ROUTE_W +: ROUTE_W] == ROUTE_W'(l)))
                        irq_line[l] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/event_timer.sv
module event_timer
    import et_pkg::*;
#(
    parameter int          NCH        = 3,
    parameter int          NLINE      = 4,
    parameter int          ADDR_W     = 6,
    parameter logic [31:0] TICK_FS    = 32'd69841279,
    parameter bit          LEGACY_CAP = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq_tick,
    output logic              irq_rtc,
    output logic [NLINE-1:0]  irq_line
);
    localparam int ROUTE_W = (NLINE > 1) ? $clog2(NLINE) : 1;

    typedef struct packed {
        logic run;
        logic leg;
    } glb_st_t;

    glb_st_t g_d, g_q;

    logic                   run;
    logic                   legacy;
    logic [CW-1:0]          cnt;
    logic [NCH-1:0]         pend;
    logic [NCH-1:0]         ch_irq;
    logic [NCH*ROUTE_W-1:0] route_flat;
    logic [NCH-1:0]         wr_cfg, wr_lo, wr_hi, clr;
    logic [DW-1:0]          ch_cfg [NCH];
    logic [CW-1:0]          ch_cmp [NCH];
    logic                   wr_cnt_lo, wr_cnt_hi;

    // global control register
    always_comb begin
        g_d = g_q;
        if (bus_wr && (bus_addr == ADDR_W'(A_GCFG))) begin
            g_d.run = bus_wdata[G_RUN];
            g_d.leg = bus_wdata[G_LEG] & LEGACY_CAP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign run    = g_q.run;
    assign legacy = g_q.leg;

    // write decode
    assign wr_cnt_lo = bus_wr && (bus_addr == ADDR_W'(A_CNT_LO));
    assign wr_cnt_hi = bus_wr && (bus_addr == ADDR_W'(A_CNT_HI));

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            wr_cfg[c] = bus_wr && (bus_addr == ADDR_W'(A_CH_BASE + A_CH_STRIDE*c + S_CFG));
            wr_lo[c]  = bus_wr && (bus_addr == ADDR_W'(A_CH_BASE + A_CH_STRIDE*c + S_CMP_LO));
            wr_hi[c]  = bus_wr && (bus_addr == ADDR_W'(A_CH_BASE + A_CH_STRIDE*c + S_CMP_HI));
            clr[c]    = bus_wr && (bus_addr == ADDR_W'(A_STAT)) && bus_wdata[c];
        end
    end

    et_counter u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .wr_lo (wr_cnt_lo),
        .wr_hi (wr_cnt_hi),
        .wdata (bus_wdata),
        .cnt   (cnt)
    );

    for (genvar c = 0; c < NCH; c++) begin : gen_ch
        et_channel #(.ROUTE_W(ROUTE_W)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run),
            .cnt    (cnt),
            .wr_cfg (wr_cfg[c]),
            .wr_lo  (wr_lo[c]),
            .wr_hi  (wr_hi[c]),
            .wdata  (bus_wdata),
            .clr    (clr[c]),
            .cfg_rd (ch_cfg[c]),
            .cmp    (ch_cmp[c]),
            .pend   (pend[c]),
            .irq    (ch_irq[c]),
            .route  (route_flat[c*ROUTE_W +: ROUTE_W])
        );
    end

    et_irq_route #(.NCH(NCH), .NLINE(NLINE), .ROUTE_W(ROUTE_W)) u_route (
        .irq        (ch_irq),
        .route_flat (route_flat),
        .legacy     (legacy),
        .irq_tick   (irq_tick),
        .irq_rtc    (irq_rtc),
        .irq_line   (irq_line)
    );

    // read mux; R5 anything not matched reads zero
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_ID)) begin
            bus_rdata[4:0] = 5'(NCH - 1);
            bus_rdata[7]   = LEGACY_CAP;
        end else if (bus_addr == ADDR_W'(A_PERIOD)) begin
            bus_rdata = TICK_FS;
        end else if (bus_addr == ADDR_W'(A_GCFG)) begin
            bus_rdata[G_RUN] = g_q.run;
            bus_rdata[G_LEG] = g_q.leg;
        end else if (bus_addr == ADDR_W'(A_STAT)) begin
            bus_rdata[NCH-1:0] = pend;
        end else if (bus_addr == ADDR_W'(A_CNT_LO)) begin
            bus_rdata = cnt[DW-1:0];
        end else if (bus_addr == ADDR_W'(A_CNT_HI)) begin
            bus_rdata = cnt[CW-1:DW];
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (bus_addr == ADDR_W'(A_CH_BASE + A_CH_STRIDE*c + S_CFG))
                    bus_rdata = ch_cfg[c];
                if (bus_addr == ADDR_W'(A_CH_BASE + A_CH_STRIDE*c + S_CMP_LO))
                    bus_rdata = ch_cmp[c][DW-1:0];
                if (bus_addr == ADDR_W'(A_CH_BASE + A_CH_STRIDE*c + S_CMP_HI))
                    bus_rdata = ch_cmp[c][CW-1:DW];
            end
        end
    end
endmodule

// File: rtl/et_checker.sv
module et_checker
    import et_pkg::*;
#(
    parameter int NCH    = 3,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic              run,
    input logic [CW-1:0]     cnt,
    input logic [NCH-1:0]    pend,
    input logic              legacy,
    input logic              irq_tick,
    input logic              irq_rtc
);
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> cnt == $past(cnt) + CW'(1)); // R3

    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !bus_wr) |=> $stable(cnt)); // R3

    AST_LEGACY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !legacy |-> (!irq_tick && !irq_rtc)); // R10

    for (genvar c = 0; c < NCH; c++) begin : gen_pend
        AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[c] && !(bus_wr && (bus_addr == ADDR_W'(A_STAT)) && bus_wdata[c]))
            |=> pend[c]); // R6

        AST_PEND_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend[c]) |-> $past(run)); // R6
    end
endmodule

bind event_timer et_checker #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .run       (run),
    .cnt       (cnt),
    .pend      (pend),
    .legacy    (legacy),
    .irq_tick  (irq_tick),
    .irq_rtc   (irq_rtc)
);

// File: tb/event_timer_test.sv
module event_timer_test;
    localparam int          CLK_PERIOD = 10;
    localparam int          NCH        = 3;
    localparam int          NLINE      = 4;
    localparam int          ADDR_W     = 6;
    localparam logic [31:0] TICK_FS    = 32'd69841279;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq_tick, irq_rtc;
    logic [NLINE-1:0]  irq_line;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    event_timer #(.NCH(NCH), .NLINE(NLINE), .ADDR_W(ADDR_W), .TICK_FS(TICK_FS)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_tick(irq_tick), .irq_rtc(irq_rtc), .irq_line(irq_line)
    );

    typedef struct packed {
        logic [5:0]  a;
        logic [31:0] e;
        logic [3:0]  r;
    } vec_t;

    // reset-state reads (R1), identity (R2), holes (R5)
    localparam vec_t RST_TAB [14] = '{
        '{6'd0,  32'h0000_0082, 4'd2},
        '{6'd1,  TICK_FS,       4'd2},
        '{6'd2,  32'h0,         4'd1},
        '{6'd3,  32'h0,         4'd1},
        '{6'd4,  32'h0,         4'd1},
        '{6'd5,  32'h0,         4'd1},
        '{6'd8,  32'h0,         4'd1},
        '{6'd9,  32'hFFFF_FFFF, 4'd1},
        '{6'd10, 32'hFFFF_FFFF, 4'd1},
        '{6'd16, 32'h0,         4'd1},
        '{6'd6,  32'h0,         4'd5},
        '{6'd7,  32'h0,         4'd5},
        '{6'd11, 32'h0,         4'd5},
        '{6'd20, 32'h0,         4'd5}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    function automatic bit sig(input int w);
        if (w < NLINE) return irq_line[w];
        if (w == NLINE) return irq_tick;
        return irq_rtc;
    endfunction

    task automatic wait_irq(input int w);
        for (int k = 0; k < 500; k++) begin
            if (sig(w)) break;
            @(negedge clk);
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v0, v1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 outputs quiet after reset
        chk_eq("R1 irq outputs", {29'd0, irq_tick, irq_rtc, |irq_line}, 32'd0);
        for (int i = 0; i < 14; i++) begin
            rd(RST_TAB[i].a, v);
            chk_eq($sformatf("R%0d read word %0d", RST_TAB[i].r, RST_TAB[i].a), v, RST_TAB[i].e);
        end

        // R2 legal tick period range
        rd(6'd1, v);
        chk((v >= 32'd100000) && (v <= 32'd100000000), "R2 period range", v, TICK_FS);

        // R5 hole and identity writes ignored
        wr(6'd6, 32'hFFFF_FFFF);
        rd(6'd6, v);  chk_eq("R5 hole write", v, 32'h0);
        wr(6'd0, 32'h0);
        rd(6'd0, v);  chk_eq("R2 identity read-only", v, 32'h82);
        rd(6'd2, v);  chk_eq("R5 control untouched", v, 32'h0);

        // R3 counting and freezing
        wr(6'd2, 32'h1);
        @(negedge clk);
        rd(6'd4, v0);
        repeat (5) @(negedge clk);
        rd(6'd4, v1);
        chk_eq("R3 advance by 5", v1, v0 + 32'd5);

        // R4 write while running ignored
        rd(6'd4, v0);
        wr(6'd4, 32'h0000_1234);
        rd(6'd4, v1);
        chk_eq("R4 running write ignored", v1, v0 + 32'd1);

        wr(6'd2, 32'h0);
        rd(6'd4, v0);
        repeat (5) @(negedge clk);
        rd(6'd4, v1);
        chk_eq("R3 frozen", v1, v0);

        // R4 stopped writes land
        wr(6'd4, 32'hCAFE_0001);
        wr(6'd5, 32'h0000_00A5);
        rd(6'd4, v);  chk_eq("R4 low half", v, 32'hCAFE_0001);
        rd(6'd5, v);  chk_eq("R4 high half", v, 32'h0000_00A5);

        // R6 / R12 one-shot on ch0, disabled ch1
        wr(6'd4, 32'h0);
        wr(6'd5, 32'h0);
        wr(6'd8,  32'h1);
        wr(6'd9,  32'd20);
        wr(6'd10, 32'h0);
        wr(6'd12, 32'h10);
        wr(6'd13, 32'd10);
        wr(6'd14, 32'h0);
        wr(6'd2, 32'h1);
        wait_irq(0);
        rd(6'd4, v);  chk_eq("R6 fire count", v, 32'd21);
        rd(6'd3, v);  chk_eq("R12 only ch0 pending", v, 32'h1);
        chk_eq("R12 ch1 line quiet", {31'd0, irq_line[1]}, 32'd0);
        repeat (3) @(negedge clk);
        chk_eq("R6 level held", {31'd0, irq_line[0]}, 32'd1);
        rd(6'd9, v);  chk_eq("R6 one-shot comparator", v, 32'd20);
        wr(6'd3, 32'h1);
        chk_eq("R6 cleared line", {31'd0, irq_line[0]}, 32'd0);
        rd(6'd3, v);  chk_eq("R6 cleared status", v, 32'h0);

        // R7 / R8 periodic on ch2, route 2
        wr(6'd2, 32'h0);
        wr(6'd4, 32'h0);
        wr(6'd5, 32'h0);
        wr(6'd16, 32'h27);
        wr(6'd17, 32'd30);
        wr(6'd17, 32'd50);
        wr(6'd18, 32'h0);
        rd(6'd16, v);  chk_eq("R8 set-value reads 0", v, 32'h23);
        rd(6'd17, v);  chk_eq("R8 first load is comparator", v, 32'd30);
        wr(6'd2, 32'h1);
        wait_irq(2);
        rd(6'd4, v);   chk_eq("R7 first match count", v, 32'd31);
        rd(6'd17, v);  chk_eq("R7 comparator advanced", v, 32'd80);
        wr(6'd3, 32'h4);
        chk_eq("R7 line cleared", {31'd0, irq_line[2]}, 32'd0);
        wait_irq(2);
        rd(6'd4, v);   chk_eq("R7 counter not cleared", v, 32'd81);
        rd(6'd17, v);  chk_eq("R7 second advance", v, 32'd130);

        // R11 then R10 routing
        wr(6'd2, 32'h0);
        wr(6'd3, 32'h7);
        wr(6'd16, 32'h0);
        wr(6'd4, 32'h0);
        wr(6'd5, 32'h0);
        wr(6'd12, 32'h31);
        wr(6'd13, 32'd5);
        wr(6'd9, 32'd3);
        wr(6'd2, 32'h1);
        repeat (12) @(negedge clk);
        chk_eq("R11 lines 0 and 3", {28'd0, irq_line}, 32'h9);
        chk_eq("R10 fixed pins low", {30'd0, irq_tick, irq_rtc}, 32'h0);
        wr(6'd2, 32'h3);
        chk_eq("R10 fixed pins high", {30'd0, irq_tick, irq_rtc}, 32'h3);
        chk_eq("R10 lines released", {28'd0, irq_line}, 32'h0);
        rd(6'd2, v);  chk_eq("R10 control readback", v, 32'h3);

        // R9 32-bit mode, stale comparator waits for wrap
        wr(6'd2, 32'h0);
        wr(6'd3, 32'h7);
        wr(6'd12, 32'h0);
        wr(6'd8, 32'h9);
        wr(6'd9, 32'd5);
        wr(6'd10, 32'h0000_1234);
        wr(6'd4, 32'hFFFF_FFF0);
        wr(6'd5, 32'h0);
        wr(6'd2, 32'h1);
        repeat (8) @(negedge clk);
        chk_eq("R9 no early fire", {31'd0, irq_line[0]}, 32'd0);
        wait_irq(0);
        rd(6'd4, v);  chk_eq("R9 fire after wrap low", v, 32'd6);
        rd(6'd5, v);  chk_eq("R9 fire after wrap high", v, 32'd1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule